// File: doc/BRIEF.md
# Johnson Decade Counter With Decoded Outputs

This block divides a stream of count ticks by ten. The count lives in a 5-bit twisted-ring register: on every counted tick the register shifts by one place and the inverted top bit re-enters at the bottom. The ring therefore fills with ones from the bottom and then drains, giving ten distinct states. A decoder examines only two adjacent ring bits per output and turns each state into one of ten one-hot lines, so no binary decoder is needed. A carry line, taken straight from the top ring bit, runs at one tenth of the tick rate with an even duty cycle. It can feed the tick input of a following stage, so stages chain into longer decimal dividers.

Everything runs on one system clock. A tick is counted at a rising clock edge when `countTick` is high. A high `inhibit` freezes the count. A high `clear` returns the counter to digit zero at the next edge and overrides both other inputs. If the ring ever holds a pattern outside the ten legal states, the next counted tick returns it to digit zero.

Top module: `decade_counter`

## Requirements
- R1: A rising clock edge with `clear` high puts the counter in digit zero: `digitOut` equals 10'b00_0000_0001 (bit 0 = digit zero) and `carryOut` is high.
- R2: After the first clear, exactly one bit of `digitOut` is high in every cycle.
- R3: A rising edge with `countTick` high and both `inhibit` and `clear` low moves the active output from bit i to bit i+1; from bit 9 it wraps to bit 0.
- R4: `carryOut` is high while digit 0 to 4 is active and low while digit 5 to 9 is active. Under continuous counting it is therefore a square wave with a period of ten ticks.
- R5: A rising edge with `countTick` low and `clear` low leaves `digitOut` and `carryOut` unchanged.
- R6: A rising edge with `inhibit` high and `clear` low leaves `digitOut` and `carryOut` unchanged, whatever the level of `countTick`.
- R7: `clear` takes priority. A rising edge with `clear`, `inhibit` and `countTick` all high still yields digit zero.
- R8: The counted tick that leaves digit 9 makes `carryOut` rise in the same cycle in which bit 0 of `digitOut` becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clear | input | 1 | Synchronous return to digit zero, highest priority |
| countTick | input | 1 | Count one step at this edge when high |
| inhibit | input | 1 | Freeze the count while high |
| digitOut | output | 10 | One-hot decoded digit, bit k = digit k |
| carryOut | output | 1 | High for digits 0 to 4, low for digits 5 to 9 |

## Verification
The ring is the only register, and both outputs are decoded from it without further registers. Every result is therefore due exactly one rising edge after the inputs that caused it: a clear, a counted tick or a held cycle shows at the outputs in the cycle that follows that edge. The bench changes the inputs on falling edges. A behavioural reference, a plain integer digit updated on each rising edge, is compared with both outputs on the next falling edge. The directed checks for clearing, holding, inhibiting and wrapping sample at that same point, one edge after their stimulus.

// File: rtl/decade_pkg.sv
package decade_pkg;

  // strobes passed from the control to the ring datapath
  typedef struct packed {
    logic zero;   // force the ring to the all-zero pattern
    logic step;   // shift the ring by one position
  } ringStrobe_t;

  // number of places where adjacent ring bits differ (non-circular)
  function automatic int unsigned edgeCount(input logic [31:0] ring, input int unsigned bits);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i + 1 < bits; i++) begin
      if (ring[i] != ring[i+1]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic        clear,
  input  logic        countTick,
  input  logic        inhibit,
  output ringStrobe_t strobe
);

  always_comb begin
    strobe.zero = clear;
    strobe.step = countTick && !inhibit && !clear;
  end

endmodule

// File: rtl/decade_ring.sv
module decade_ring
  import decade_pkg::*;
#(
  parameter int unsigned RING_BITS = 5
) (
  input  logic                 clk,
  input  ringStrobe_t          strobe,
  output logic [RING_BITS-1:0] ringQ,
  output logic                 carryQ
);

  logic [RING_BITS-1:0] ringNext;
  logic [31:0]          ringWide;
  logic                 legal;

  always_comb begin
    ringWide = '0;
    ringWide[RING_BITS-1:0] = ringQ;
    // a legal twisted-ring pattern is a run of ones and a run of zeros
    legal = (edgeCount(ringWide, RING_BITS) <= 1);
  end

  always_comb begin
    ringNext = ringQ;
    if (strobe.zero) begin
      ringNext = '0;
    end else if (strobe.step) begin
      if (legal) ringNext = {ringQ[RING_BITS-2:0], ~ringQ[RING_BITS-1]};
      else       ringNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    ringQ <= ringNext;
  end

  // top bit is low for the first half of the cycle
  assign carryQ = ~ringQ[RING_BITS-1];

endmodule

// File: rtl/decade_decode.sv
module decade_decode #(
  parameter int unsigned RING_BITS = 5,
  localparam int unsigned OUT_COUNT = 2 * RING_BITS
) (
  input  logic [RING_BITS-1:0] ringQ,
  output logic [OUT_COUNT-1:0] digitQ
);

  for (genvar k = 0; k < OUT_COUNT; k++) begin : g_digit
    if (k == 0) begin : g_empty
      assign digitQ[k] = ~ringQ[0] & ~ringQ[RING_BITS-1];
    end else if (k < RING_BITS) begin : g_fill
      assign digitQ[k] = ringQ[k-1] & ~ringQ[k];
    end else if (k == RING_BITS) begin : g_full
      assign digitQ[k] = ringQ[0] & ringQ[RING_BITS-1];
    end else begin : g_drain
      assign digitQ[k] = ~ringQ[k-RING_BITS-1] & ringQ[k-RING_BITS];
    end
  end

endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_pkg::*;
#(
  parameter int unsigned RING_BITS = 5,
  localparam int unsigned OUT_COUNT = 2 * RING_BITS
) (
  input  logic                 clk,
  input  logic                 clear,
  input  logic                 countTick,
  input  logic                 inhibit,
  output logic [OUT_COUNT-1:0] digitOut,
  output logic                 carryOut
);

  ringStrobe_t          strobe;
  logic [RING_BITS-1:0] ringQ;

  decade_ctrl u_ctrl (
    .clear     (clear),
    .countTick (countTick),
    .inhibit   (inhibit),
    .strobe    (strobe)
  );

  decade_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk    (clk),
    .strobe (strobe),
    .ringQ  (ringQ),
    .carryQ (carryOut)
  );

  decade_decode #(.RING_BITS(RING_BITS)) u_decode (
    .ringQ  (ringQ),
    .digitQ (digitOut)
  );

endmodule

// File: rtl/decade_counter_chk.sv
module decade_counter_chk #(
  parameter int unsigned OUT_COUNT = 10,
  localparam int unsigned HALF = OUT_COUNT / 2
) (
  input logic                 clk,
  input logic                 clear,
  input logic                 countTick,
  input logic                 inhibit,
  input logic [OUT_COUNT-1:0] digitOut,
  input logic                 carryOut
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | clear;

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!armed)
    clear |=> (digitOut == OUT_COUNT'(1)) && carryOut); // R1

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!armed)
    $onehot(digitOut)); // R2

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!armed)
    (countTick && !inhibit && !clear) |=>
      digitOut == {$past(digitOut[OUT_COUNT-2:0]), $past(digitOut[OUT_COUNT-1])}); // R3

  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (!armed)
    carryOut == (|digitOut[HALF-1:0])); // R4

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!armed)
    (!countTick && !clear) |=> $stable(digitOut) && $stable(carryOut)); // R5

  AST_HOLD_INHIBIT: assert property (@(posedge clk) disable iff (!armed)
    (inhibit && !clear) |=> $stable(digitOut) && $stable(carryOut)); // R6

  AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!armed)
    (digitOut[OUT_COUNT-1] && countTick && !inhibit && !clear) |=> $rose(carryOut) && digitOut[0]); // R8

endmodule

bind decade_counter decade_counter_chk #(.OUT_COUNT(OUT_COUNT)) u_chk (
  .clk       (clk),
  .clear     (clear),
  .countTick (countTick),
  .inhibit   (inhibit),
  .digitOut  (digitOut),
  .carryOut  (carryOut)
);

// File: tb/decade_counter_bench.sv
module decade_counter_bench;

  logic       clk = 1'b0;
  logic       clear = 1'b0;
  logic       countTick = 1'b0;
  logic       inhibit = 1'b0;
  logic [9:0] digitOut;
  logic       carryOut;

  int checks = 0;
  int errors = 0;
  int refDigit = 0;
  bit refValid = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  decade_counter u_decade_counter (
    .clk       (clk),
    .clear     (clear),
    .countTick (countTick),
    .inhibit   (inhibit),
    .digitOut  (digitOut),
    .carryOut  (carryOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference: a plain decimal digit
  always @(posedge clk) begin
    if (clear) begin
      refDigit <= 0;
      refValid <= 1'b1;
    end else if (countTick && !inhibit) begin
      refDigit <= (refDigit + 1) % 10;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (refValid) begin
      check($countones(digitOut) == 1, "R2 one-hot", $countones(digitOut), 1);
      check(digitOut == 10'(1 << refDigit), "R3 digit", int'(digitOut), 1 << refDigit);
      check(carryOut == (refDigit < 5), "R4 carry", int'(carryOut), int'(refDigit < 5));
    end
  end

  task automatic drive(input bit c, input bit t, input bit i);
    @(negedge clk);
    clear = c;
    countTick = t;
    inhibit = i;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0 at %0t", $time);
    finish_run();
  end

  initial begin
    logic [9:0] held;
    logic       heldCarry;
    int         rises;
    logic       prevCarry;
    int unsigned lfsr;

    // R1: reset state
    drive(1, 0, 0);
    drive(0, 0, 0);
    check(digitOut == 10'd1, "R1 digit after clear", int'(digitOut), 1);
    check(carryOut == 1'b1, "R1 carry after clear", int'(carryOut), 1);

    // R3 R4: free counting, count carry rises over 30 ticks
    rises = 0;
    prevCarry = carryOut;
    for (int n = 0; n < 30; n++) begin
      drive(0, 1, 0);
      if (n > 0) begin
        if (carryOut && !prevCarry) rises++;
        prevCarry = carryOut;
      end
    end
    drive(0, 0, 0);
    if (carryOut && !prevCarry) rises++;
    check(rises == 3, "R4 carry period ten", rises, 3);
    check(digitOut == 10'd1, "R3 digit after 30 ticks", int'(digitOut), 1);

    // advance to digit 7, then R5 hold with tick low
    for (int n = 0; n < 7; n++) drive(0, 1, 0);
    drive(0, 0, 0);
    held = digitOut;
    heldCarry = carryOut;
    check(held == 10'(1 << 7), "R3 digit seven", int'(held), 1 << 7);
    for (int n = 0; n < 3; n++) drive(0, 0, 0);
    drive(0, 0, 0);
    check(digitOut == held && carryOut == heldCarry, "R5 hold without tick", int'(digitOut), int'(held));

    // R6: inhibit freezes despite ticks
    for (int n = 0; n < 5; n++) drive(0, 1, 1);
    drive(0, 0, 0);
    check(digitOut == held, "R6 inhibit digit", int'(digitOut), int'(held));
    check(carryOut == heldCarry, "R6 inhibit carry", int'(carryOut), int'(heldCarry));

    // R8: from 7 go to 9, then wrap
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(0, 0, 0);
    check(digitOut == 10'(1 << 9) && !carryOut, "R8 at digit nine", int'(digitOut), 1 << 9);
    drive(0, 1, 0);
    drive(0, 0, 0);
    check(digitOut == 10'd1, "R8 wrap digit", int'(digitOut), 1);
    check(carryOut == 1'b1, "R8 wrap carry", int'(carryOut), 1);

    // R7: clear beats inhibit and tick
    for (int n = 0; n < 4; n++) drive(0, 1, 0);
    drive(1, 1, 1);
    drive(0, 0, 1);
    check(digitOut == 10'd1, "R7 clear priority", int'(digitOut), 1);
    check(carryOut == 1'b1, "R7 clear carry", int'(carryOut), 1);

    // mixed pattern, compared by the reference each cycle
    lfsr = 32'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[7:0] == 8'h5A, lfsr[3] | lfsr[9], lfsr[5] & lfsr[12]);
    end
    drive(0, 0, 0);
    drive(0, 0, 0);
    finish_run();
  end

endmodule